// File: doc/BRIEF.md
# Two-Bank FSK Phase-Accumulator Synthesizer

This block is the digital core of a direct digital synthesizer with built-in two-tone frequency-shift keying. It holds two frequency tuning words, one per configuration bank, plus an 8-bit deviation word. On every reference-clock cycle it builds a frequency increment from the bank picked by `bank_sel` and the live data bit `tx_bit`, adds that increment to a 24-bit phase register, and turns the upper phase bits into an 11-bit offset-binary sine sample for an external converter.

The configuration words are loaded through a small write port. A write selects a target with `wr_sel`: a bank frequency word together with its run-enable bit, or the deviation word. The stored values stay in place while the block is in standby. The accumulator runs only while standby is off and the run-enable bit of the currently selected bank is set. Otherwise the phase is held at zero and the output sits at mid-scale. Switching bank or data bit changes only the step size, so the phase stays continuous.

Top module: `fsk_syn_top`

## Requirements
- R1: During and right after an active-low reset, `phase_o` is 0 and `sample_o` is 1024. Both bank words, both run-enable bits and the deviation word are cleared to zero.
- R2: While running, `phase_o` advances by the increment at every clock edge. The sum wraps modulo 2^24 and has no carry out.
- R3: The increment is the selected 22-bit bank word placed in bits 21..0, with bits 23..22 zero. `bank_sel`=0 takes bank 0 and `bank_sel`=1 takes bank 1.
- R4: With `tx_bit`=1, the deviation word is added at increment bits 9..2 (4 × deviation). With `tx_bit`=0, no deviation is added.
- R5: For a phase value p, let h = p[22:14], k = 2h+1 and m = floor(1023·16·k·(1024−k) / (5·1024² − 4·k·(1024−k))). The sample is 1024+m when p[23]=0 and 1023−m when p[23]=1.
- R6: When `standby`=1, or when the selected bank's run-enable bit is 0, the next edge sets `phase_o` to 0 and `sample_o` to 1024.
- R7: The configuration words keep their values through standby, and writes made during standby are accepted.
- R8: A change of `bank_sel` or `tx_bit` alters the step at the next edge without resetting the phase.
- R9: Write encoding: `wr_sel`=0 loads bank 0 as {enable=`wr_data`[22], word=`wr_data`[21:0]}. `wr_sel`=1 loads bank 1 in the same layout. `wr_sel`=2 loads the deviation from `wr_data`[7:0]. `wr_sel`=3 changes nothing. A write takes effect for the step after the edge that captures it.
- R10: `sample_o` is registered. After an edge it shows the shaped value of the phase held just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby, active high; holds the synthesizer idle |
| bank_sel | input | 1 | Configuration bank select |
| tx_bit | input | 1 | FSK data bit; 1 adds the deviation |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target |
| wr_data | input | 23 | Write data |
| sample_o | output | 11 | Offset-binary sine sample |
| phase_o | output | 24 | Phase accumulator value |

## Verification
Two cases are hard to reach from the ports: the 2^24 wrap, and a carry from the deviation add into increment bit 22. Both need the largest tuning word (0x3FFFFF) together with the largest deviation. The bench loads these values and then runs with the data bit high, so the phase wraps within a few cycles. Retention through standby is also awkward to see, because nothing shows the stored words while the block is idle. To expose it, the bench writes a new bank word during standby, leaves the deviation untouched, and then infers both stored values from the phase steps that follow standby exit.

// File: rtl/fsk_syn_pkg.sv
package fsk_syn_pkg;

  typedef enum logic [1:0] {
    SEL_BANK0 = 2'd0,
    SEL_BANK1 = 2'd1,
    SEL_DEV   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  // Rational sine approximation on a half wave of span 'span' (pi <-> span),
  // evaluated at odd point k, scaled to 'amp'.
  function automatic int half_wave_mag(input int k, input int span, input int amp);
    longint prod;
    longint num;
    longint den;
    prod = longint'(k) * longint'(span - k);
    num  = longint'(amp) * 16 * prod;
    den  = 5 * longint'(span) * longint'(span) - 4 * prod;
    return int'(num / den);
  endfunction

  // Magnitude of quarter-table entry g for a table of 2**lut_aw entries.
  function automatic int quarter_mag(input int g, input int lut_aw, input int amp);
    return half_wave_mag(2 * g + 1, 4 << lut_aw, amp);
  endfunction

endpackage

// File: rtl/fsk_cfg_regs.sv
module fsk_cfg_regs
  import fsk_syn_pkg::*;
#(
  parameter int FW_W  = 22,
  parameter int DEV_W = 8,
  localparam int WD_W = FW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WD_W-1:0]  wr_data,
  output logic [FW_W-1:0]  word0,
  output logic [FW_W-1:0]  word1,
  output logic             en0,
  output logic             en1,
  output logic [DEV_W-1:0] dev
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word0 <= '0;
      word1 <= '0;
      en0   <= 1'b0;
      en1   <= 1'b0;
      dev   <= '0;
    end else if (wr_en) begin
      case (cfg_sel_e'(wr_sel))
        SEL_BANK0: {en0, word0} <= wr_data;
        SEL_BANK1: {en1, word1} <= wr_data;
        SEL_DEV:   dev <= wr_data[DEV_W-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/fsk_incr_compose.sv
module fsk_incr_compose #(
  parameter int PH_W    = 24,
  parameter int FW_W    = 22,
  parameter int DEV_W   = 8,
  parameter int DEV_LSB = 2
) (
  input  logic [FW_W-1:0]  word0,
  input  logic [FW_W-1:0]  word1,
  input  logic [DEV_W-1:0] dev,
  input  logic             bank_sel,
  input  logic             tx_bit,
  output logic [PH_W-1:0]  inc
);

  function automatic logic [PH_W-1:0] build_inc(
    input logic [FW_W-1:0]  w,
    input logic [DEV_W-1:0] d,
    input logic             add_dev
  );
    logic [PH_W-1:0] base;
    logic [PH_W-1:0] offs;
    base = PH_W'(w);
    offs = add_dev ? (PH_W'(d) << DEV_LSB) : '0;
    return base + offs;
  endfunction

  logic [FW_W-1:0] sel_word;

  always_comb begin
    sel_word = bank_sel ? word1 : word0;
    inc      = build_inc(sel_word, dev, tx_bit);
  end

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int PH_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PH_W-1:0] inc,
  output logic [PH_W-1:0] phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (!run)   phase <= '0;
    else             phase <= phase + inc;
  end

endmodule

// File: rtl/fsk_sine_shaper.sv
module fsk_sine_shaper
  import fsk_syn_pkg::*;
#(
  parameter int OUT_W  = 11,
  parameter int LUT_AW = 8,
  localparam int TOP_W = LUT_AW + 2,
  localparam int MAG_W = OUT_W - 1,
  localparam int LUT_N = 1 << LUT_AW,
  localparam int AMP   = (1 << MAG_W) - 1,
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << MAG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TOP_W-1:0] ph_top,
  output logic [OUT_W-1:0] sample
);

  logic [MAG_W-1:0] qtab [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_qtab
    assign qtab[g] = MAG_W'(quarter_mag(g, LUT_AW, AMP));
  end

  logic              neg_half;
  logic              mirror;
  logic [LUT_AW-1:0] idx;
  logic [MAG_W-1:0]  mag;
  logic [OUT_W-1:0]  shaped;

  always_comb begin
    neg_half = ph_top[TOP_W-1];
    mirror   = ph_top[TOP_W-2];
    idx      = mirror ? ~ph_top[LUT_AW-1:0] : ph_top[LUT_AW-1:0];
    mag      = qtab[idx];
    shaped   = neg_half ? (MID - 1'b1 - OUT_W'(mag)) : (MID + OUT_W'(mag));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sample <= MID;
    else if (!run) sample <= MID;
    else           sample <= shaped;
  end

endmodule

// File: rtl/fsk_syn_top.sv
module fsk_syn_top #(
  parameter int PH_W    = 24,
  parameter int FW_W    = 22,
  parameter int DEV_W   = 8,
  parameter int DEV_LSB = 2,
  parameter int OUT_W   = 11,
  parameter int LUT_AW  = 8,
  localparam int WD_W   = FW_W + 1,
  localparam int TOP_W  = LUT_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              bank_sel,
  input  logic              tx_bit,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WD_W-1:0]   wr_data,
  output logic [OUT_W-1:0]  sample_o,
  output logic [PH_W-1:0]   phase_o
);

  logic [FW_W-1:0]  word0_w;
  logic [FW_W-1:0]  word1_w;
  logic             en0_w;
  logic             en1_w;
  logic [DEV_W-1:0] dev_w;
  logic [PH_W-1:0]  inc_w;
  logic             run_w;

  fsk_cfg_regs #(.FW_W(FW_W), .DEV_W(DEV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .word0(word0_w), .word1(word1_w), .en0(en0_w), .en1(en1_w), .dev(dev_w)
  );

  fsk_incr_compose #(.PH_W(PH_W), .FW_W(FW_W), .DEV_W(DEV_W), .DEV_LSB(DEV_LSB)) u_inc (
    .word0(word0_w), .word1(word1_w), .dev(dev_w),
    .bank_sel(bank_sel), .tx_bit(tx_bit), .inc(inc_w)
  );

  assign run_w = !standby && (bank_sel ? en1_w : en0_w);

  fsk_phase_acc #(.PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(run_w), .inc(inc_w), .phase(phase_o)
  );

  fsk_sine_shaper #(.OUT_W(OUT_W), .LUT_AW(LUT_AW)) u_shp (
    .clk(clk), .rst_n(rst_n), .run(run_w),
    .ph_top(phase_o[PH_W-1 -: TOP_W]), .sample(sample_o)
  );

endmodule

// File: rtl/fsk_syn_chk.sv
module fsk_syn_chk #(
  parameter int PH_W  = 24,
  parameter int FW_W  = 22,
  parameter int OUT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_bit,
  input logic             wr_en,
  input logic             standby,
  input logic             run_w,
  input logic [PH_W-1:0]  inc_w,
  input logic [FW_W-1:0]  word0_w,
  input logic [PH_W-1:0]  phase_o,
  input logic [OUT_W-1:0] sample_o
);

  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (phase_o == '0 && sample_o == MID));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_w |=> (phase_o == $past(phase_o + inc_w)));

  // R3
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |-> (inc_w[PH_W-1 -: 2] == 2'b00));

  // R6
  idle_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> (phase_o == '0 && sample_o == MID));

  // R7
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !wr_en) |=> $stable(word0_w));

  // R10: shaped value of phase zero at default widths is mid-scale plus 3
  zero_phase_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && phase_o == '0) |=> (sample_o == MID + OUT_W'(3)));

endmodule

bind fsk_syn_top fsk_syn_chk #(.PH_W(PH_W), .FW_W(FW_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .wr_en(wr_en), .standby(standby),
  .run_w(run_w), .inc_w(inc_w), .word0_w(word0_w),
  .phase_o(phase_o), .sample_o(sample_o)
);

// File: tb/fsk_syn_top_test.sv
module fsk_syn_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        bank_sel = 1'b0;
  logic        tx_bit = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [22:0] wr_data = '0;
  logic [10:0] sample_o;
  logic [23:0] phase_o;

  int checks = 0;
  int errors = 0;

  // bench-side model state
  logic [21:0] m_w0 = '0, m_w1 = '0;
  logic        m_en0 = 1'b0, m_en1 = 1'b0;
  logic [7:0]  m_dev = '0;
  logic [23:0] m_ph = '0;

  always #10 clk = ~clk;

  fsk_syn_top uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bank_sel(bank_sel), .tx_bit(tx_bit),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sample_o(sample_o), .phase_o(phase_o)
  );

  typedef struct packed {
    logic        sb;
    logic        bk;
    logic        tx;
    logic        we;
    logic [1:0]  sel;
    logic [22:0] d;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t [0:NV-1] VECS = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd0, {1'b1, 22'h012345}},
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd1, {1'b1, 22'h200000}},
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 23'h000080},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 23'h0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 23'h7FFFFF},
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd1, {1'b0, 22'h100000}},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 23'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 23'h0}
  };

  // Expected sample from the phase: half-wave position and sign, evaluated directly.
  function automatic int ref_sample(input logic [23:0] ph);
    longint k, prod, m;
    k    = 2 * longint'(ph[22:14]) + 1;
    prod = k * (1024 - k);
    m    = (longint'(1023) * 16 * prod) / (longint'(5) * 1024 * 1024 - 4 * prod);
    return ph[23] ? int'(1023 - m) : int'(1024 + m);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives inputs, predicts, waits one cycle, checks.
  task automatic step(input logic sb, input logic bk, input logic tx, input logic we,
                      input logic [1:0] sel, input logic [22:0] d, input string tag);
    logic        run;
    logic [23:0] inc, ep;
    int          es;
    standby = sb; bank_sel = bk; tx_bit = tx; wr_en = we; wr_sel = sel; wr_data = d;
    run = !sb && (bk ? m_en1 : m_en0);
    inc = {2'b00, (bk ? m_w1 : m_w0)} + (tx ? {14'd0, m_dev, 2'b00} : 24'd0);
    ep  = run ? m_ph + inc : 24'd0;
    es  = run ? ref_sample(m_ph) : 1024;
    if (we) begin
      case (sel)
        2'd0: {m_en0, m_w0} = d;
        2'd1: {m_en1, m_w1} = d;
        2'd2: m_dev = d[7:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " phase"}, phase_o, ep);
    check({tag, " sample"}, sample_o, es);
    m_ph = ep;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held and right after release
    check("R1 phase in reset", phase_o, 0);
    check("R1 sample in reset", sample_o, 1024);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 2'd0, 23'h0, "R1");

    for (int i = 0; i < NV; i++)
      step(VECS[i].sb, VECS[i].bk, VECS[i].tx, VECS[i].we, VECS[i].sel, VECS[i].d, "R2/R5");

    // R3/R2: largest tuning word, repeated until the phase wraps
    step(0, 0, 0, 1, 2'd0, {1'b1, 22'h3FFFFF}, "R3");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 2'd0, 23'h0, "R3");
    // R4: full deviation carries into bit 22, phase wraps again
    step(0, 0, 0, 1, 2'd2, 23'h0000FF, "R4");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 2'd0, 23'h0, "R2");

    // R8: bank and data toggles keep the phase running
    step(0, 0, 0, 1, 2'd1, {1'b1, 22'h0ABCDE}, "R8");
    for (int i = 0; i < 8; i++) step(0, i[0], i[1], 0, 2'd0, 23'h0, "R8");

    // R9: unused target leaves everything unchanged
    step(0, 0, 0, 1, 2'd3, 23'h7FFFFF, "R9");
    step(0, 0, 1, 0, 2'd0, 23'h0, "R9");

    // R6/R7: standby idles; a write during standby is kept and used after exit
    step(1, 0, 0, 1, 2'd0, {1'b1, 22'h000400}, "R6");
    step(1, 0, 1, 0, 2'd0, 23'h0, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 2'd0, 23'h0, "R7");

    // R6: selected bank disabled while the other is enabled
    step(0, 1, 0, 1, 2'd1, {1'b0, 22'h0ABCDE}, "R6");
    step(0, 1, 0, 0, 2'd0, 23'h0, "R6");
    // R10: restart from phase zero, first sample is the shaped zero phase
    step(0, 0, 0, 0, 2'd0, 23'h0, "R10");
    step(0, 0, 0, 0, 2'd0, 23'h0, "R10");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule